// File: doc/BRIEF.md
# Glitch-Free Runtime-Programmable Clock Divider

This block takes a fast, free-running oscillator clock and produces a slower clock from it by an integer ratio that software sets through a small register port in a separate bus clock domain. Alongside the main divided clock it drives a second clock of the same frequency. This second clock trails the main one by a programmable number of oscillator cycles. With the lag left at zero, the two outputs are the same waveform.

The ratio and the lag can be rewritten at any time while the oscillator runs. A write is captured in the bus domain and carried into the oscillator domain by a toggle request/acknowledge handshake. It is then held as a pending setting until the running output period ends. The counter wrap is the only point where a new ratio or lag is adopted, so the outputs never carry a truncated or stretched phase.

A divisor field of zero selects the largest ratio, two to the power of the field width. A field of one routes the oscillator clock straight to both outputs through a multiplexer whose select changes only on a falling oscillator edge, at a moment when every input of the multiplexer is low.

Top module: `clkdiv_glitchless`

## Requirements
- R1: After reset, address 0 reads 16 and address 1 reads 0. clk_main then has a period of 16 oscillator cycles, high for 8 of them, and clk_shift rises together with clk_main.
- R2: A divisor field N with 2 <= N <= 255 gives clk_main a period of exactly N oscillator cycles, high for the first ceil(N/2) of them.
- R3: A divisor field of 0 gives a period of 256 oscillator cycles (2^DIV_W), high for 128 of them.
- R4: A divisor field of 1 makes clk_main and clk_shift follow the oscillator clock: period of one oscillator cycle, high for half of it.
- R5: No high or low phase on clk_main is shorter than half an oscillator cycle at any time, including across every kind of setting change.
- R6: A new divisor is adopted only when the counter wraps at the end of a period. While the divisor changes, every period of clk_main equals either the old or the new divisor.
- R7: A lag field P below the divisor delays the rising edge of clk_shift by exactly P oscillator cycles relative to clk_main. P = 0 makes both rise together.
- R8: A lag field at or above the active divisor D acts as D-1 cycles of lag.
- R9: Writes with reg_wr_en high on a bus clock edge store reg_wdata at reg_addr: 0 holds the divisor, 1 holds the lag. reg_rdata returns the raw stored field for the current reg_addr, with no clamping.
- R10: Settings cross into the oscillator domain through the handshake. Two writes on back-to-back bus cycles leave the last written value in effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register port clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| reg_wr_en | input | 1 | Write strobe |
| reg_addr | input | 1 | Register select: 0 divisor, 1 lag |
| reg_wdata | input | DIV_W | Write data |
| reg_rdata | output | DIV_W | Read data for reg_addr |
| osc_clk | input | 1 | Free-running oscillator clock |
| osc_rst_n | input | 1 | Active-low asynchronous reset, oscillator domain |
| clk_main | output | 1 | Divided clock |
| clk_shift | output | 1 | Divided clock, delayed by the lag setting |

## Verification
The hardest situation to reach is a setting arriving at an arbitrary point inside a running output period, especially the transitions into and out of the one-to-one pass-through, where a multiplexer select changes on a clock edge. The stimulus inserts random sub-period delays before each write and steps through ratios of 1, 0 (256) and small values. A free-running edge monitor timestamps every clk_main transition and flags any phase shorter than half an oscillator cycle. Over a window around each change, it also flags any period that is neither the old nor the new ratio.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam logic ADDR_DIVISOR = 1'b0;
  localparam logic ADDR_LAG     = 1'b1;

  // Effective ratio for a divisor field: zero stands for the largest ratio.
  function automatic int unsigned eff_div(int unsigned field, int unsigned width);
    return (field == 0) ? (32'd1 << width) : field;
  endfunction

  // Number of oscillator cycles the output stays high in one period.
  function automatic int unsigned high_len(int unsigned d);
    return (d + 1) / 2;
  endfunction

  // Lag is kept strictly below the active ratio.
  function automatic int unsigned lim_lag(int unsigned lag, int unsigned d);
    return (lag >= d) ? d - 1 : lag;
  endfunction

endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
  parameter int DIV_W   = 8,
  parameter int RST_DIV = 16
) (
  input  logic             bus_clk,
  input  logic             bus_rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [DIV_W-1:0] wdata,
  output logic [DIV_W-1:0] rdata,
  input  logic             ack_s,
  output logic             req_tgl,
  output logic [DIV_W-1:0] xfer_div,
  output logic [DIV_W-1:0] xfer_lag
);
  import clkdiv_pkg::*;

  logic [DIV_W-1:0] div_reg;
  logic [DIV_W-1:0] lag_reg;
  logic             dirty;
  logic             busy;
  logic             launch;

  assign busy   = req_tgl ^ ack_s;
  assign launch = dirty && !busy;

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      div_reg <= DIV_W'(RST_DIV);
      lag_reg <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_LAG) lag_reg <= wdata;
      else                  div_reg <= wdata;
    end
  end

  // A write during a launch keeps dirty set, so the newer value is sent next.
  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      dirty    <= 1'b0;
      req_tgl  <= 1'b0;
      xfer_div <= DIV_W'(RST_DIV);
      xfer_lag <= '0;
    end else begin
      if (launch) begin
        xfer_div <= div_reg;
        xfer_lag <= lag_reg;
        req_tgl  <= ~req_tgl;
      end
      if (wr_en)       dirty <= 1'b1;
      else if (launch) dirty <= 1'b0;
    end
  end

  assign rdata = (addr == ADDR_LAG) ? lag_reg : div_reg;

  // Data seen by the oscillator domain must hold still while a request is open.
  assert_xfer_stable_R10: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (busy && $past(busy)) |-> ($stable(xfer_div) && $stable(xfer_lag)));

  assert_launch_opens_R10: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    launch |=> busy);
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
  parameter int DIV_W   = 8,
  parameter int RST_DIV = 16
) (
  input  logic             osc_clk,
  input  logic             osc_rst_n,
  input  logic             req_s,
  input  logic [DIV_W-1:0] xfer_div,
  input  logic [DIV_W-1:0] xfer_lag,
  output logic             ack_tgl,
  output logic             clk_main,
  output logic             clk_shift
);
  import clkdiv_pkg::*;

  localparam int CW = DIV_W + 1;

  logic          req_seen;
  logic          upd;
  logic          pend;
  logic [CW-1:0] pend_div;
  logic [CW-1:0] pend_lag;
  logic [CW-1:0] div_cur;
  logic [CW-1:0] lag_cur;
  logic [CW-1:0] cnt;
  logic          wrap;
  logic          apply;
  logic [CW-1:0] div_nxt;
  logic [CW-1:0] lag_raw_nxt;
  logic [CW-1:0] lag_nxt;
  logic [CW-1:0] hi_cur;
  logic [CW-1:0] rel;
  logic          main_q;
  logic          shift_q;
  logic          bypass_q;
  logic          bypass_sel;

  // Request capture: a toggle seen on req_s marks new stable data.
  assign upd     = req_s ^ req_seen;
  assign ack_tgl = req_seen;

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) req_seen <= 1'b0;
    else            req_seen <= req_s;
  end

  assign wrap  = (cnt == div_cur - 1'b1);
  assign apply = wrap && pend;

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      pend     <= 1'b0;
      pend_div <= CW'(RST_DIV);
      pend_lag <= '0;
    end else begin
      if (upd) begin
        pend     <= 1'b1;
        pend_div <= CW'(eff_div(32'(xfer_div), DIV_W));
        pend_lag <= {1'b0, xfer_lag};
      end else if (apply) begin
        pend <= 1'b0;
      end
    end
  end

  assign div_nxt     = apply ? pend_div : div_cur;
  assign lag_raw_nxt = apply ? pend_lag : lag_cur;
  assign lag_nxt     = CW'(lim_lag(32'(lag_raw_nxt), 32'(div_nxt)));

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      div_cur <= CW'(RST_DIV);
      lag_cur <= '0;
      cnt     <= '0;
    end else begin
      div_cur <= div_nxt;
      lag_cur <= lag_nxt;
      cnt     <= wrap ? '0 : cnt + 1'b1;
    end
  end

  // Phase position of the delayed copy, modulo the active ratio.
  assign hi_cur = CW'(high_len(32'(div_cur)));
  assign rel    = (cnt >= lag_cur) ? (cnt - lag_cur) : (div_cur - (lag_cur - cnt));

  // Both divided outputs are held low around a move into or out of pass-through.
  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      main_q   <= 1'b0;
      shift_q  <= 1'b0;
      bypass_q <= (RST_DIV == 1);
    end else begin
      main_q   <= (div_cur != 1) && (div_nxt != 1) && (cnt < hi_cur);
      shift_q  <= (div_cur != 1) && (div_nxt != 1) && (rel < hi_cur);
      bypass_q <= (div_nxt == 1);
    end
  end

  // Select moves only while the oscillator is low.
  always_ff @(negedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) bypass_sel <= (RST_DIV == 1);
    else            bypass_sel <= bypass_q;
  end

  assign clk_main  = bypass_sel ? osc_clk : main_q;
  assign clk_shift = bypass_sel ? osc_clk : shift_q;

  assert_cnt_range_R2: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    cnt < div_cur);

  assert_apply_at_wrap_R6: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    (div_cur != $past(div_cur)) |-> $past(wrap));

  assert_lag_limit_R8: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    lag_cur < div_cur);

  assert_switch_low_R5: assert property (@(negedge osc_clk) disable iff (!osc_rst_n)
    (bypass_q != bypass_sel) |-> (!main_q && !shift_q));
endmodule

// File: rtl/clkdiv_glitchless.sv
module clkdiv_glitchless #(
  parameter int DIV_W       = 8,
  parameter int RST_DIV     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             bus_clk,
  input  logic             bus_rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_addr,
  input  logic [DIV_W-1:0] reg_wdata,
  output logic [DIV_W-1:0] reg_rdata,
  input  logic             osc_clk,
  input  logic             osc_rst_n,
  output logic             clk_main,
  output logic             clk_shift
);
  logic             req_tgl;
  logic             req_s;
  logic             ack_tgl;
  logic             ack_s;
  logic [DIV_W-1:0] xfer_div;
  logic [DIV_W-1:0] xfer_lag;

  clkdiv_regs #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_regs (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .ack_s     (ack_s),
    .req_tgl   (req_tgl),
    .xfer_div  (xfer_div),
    .xfer_lag  (xfer_lag)
  );

  clkdiv_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (osc_clk),
    .rst_n (osc_rst_n),
    .d     (req_tgl),
    .q     (req_s)
  );

  clkdiv_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (bus_clk),
    .rst_n (bus_rst_n),
    .d     (ack_tgl),
    .q     (ack_s)
  );

  clkdiv_core #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_core (
    .osc_clk   (osc_clk),
    .osc_rst_n (osc_rst_n),
    .req_s     (req_s),
    .xfer_div  (xfer_div),
    .xfer_lag  (xfer_lag),
    .ack_tgl   (ack_tgl),
    .clk_main  (clk_main),
    .clk_shift (clk_shift)
  );
endmodule

// File: tb/clkdiv_glitchless_tb.sv
`timescale 1ns/1ps
module clkdiv_glitchless_tb;
  localparam int DIV_W = 8;
  localparam int OT    = 6;

  logic             bus_clk = 1'b0;
  logic             osc_clk = 1'b0;
  logic             bus_rst_n = 1'b0;
  logic             osc_rst_n = 1'b0;
  logic             reg_wr_en = 1'b0;
  logic             reg_addr  = 1'b0;
  logic [DIV_W-1:0] reg_wdata = '0;
  logic [DIV_W-1:0] reg_rdata;
  logic             clk_main;
  logic             clk_shift;

  int checks = 0;
  int fails  = 0;

  always #10 bus_clk = ~bus_clk;
  always #3  osc_clk = ~osc_clk;

  clkdiv_glitchless #(.DIV_W(DIV_W)) u_dut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .osc_clk(osc_clk), .osc_rst_n(osc_rst_n),
    .clk_main(clk_main), .clk_shift(clk_shift)
  );

  // Edge monitor
  longint last_edge_t = 0;
  bit     seen_edge   = 0;
  int     glitches    = 0;
  longint last_main_rise = 0;
  longint last_sh_rise   = 0;
  bit     per_en   = 0;
  bit     have_rise = 0;
  int     win_a = 0;
  int     win_b = 0;
  int     odd_periods = 0;

  always @(clk_main) begin
    if (seen_edge && ($time - last_edge_t) < 3) glitches++;
    last_edge_t = $time;
    seen_edge   = 1;
  end

  always @(posedge clk_main) begin
    if (per_en) begin
      if (have_rise && ($time - last_main_rise) != longint'(win_a * OT)
                    && ($time - last_main_rise) != longint'(win_b * OT))
        odd_periods++;
      have_rise = 1;
    end
    last_main_rise = $time;
  end

  always @(posedge clk_shift) last_sh_rise = $time;

  function automatic int exp_period(int field);
    if (field == 0) return 256;
    return field;
  endfunction

  function automatic int exp_high(int d);
    return d - d / 2;
  endfunction

  function automatic int exp_lag(int lag, int d);
    if (lag > d - 1) return d - 1;
    return lag;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input int d);
    @(negedge bus_clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = DIV_W'(d);
    @(negedge bus_clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output int d);
    @(negedge bus_clk);
    reg_addr = a;
    #1 d = int'(reg_rdata);
  endtask

  task automatic settle();
    #(OT * 700);
  endtask

  task automatic meas(output longint per, output longint hi);
    longint t0, t1, t2;
    @(posedge clk_main); t0 = $time;
    @(negedge clk_main); t1 = $time;
    @(posedge clk_main); t2 = $time;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  task automatic meas_lag(input int lag_cycles, output longint lag_ns);
    @(posedge clk_main);
    #(lag_cycles * OT + 2);
    lag_ns = last_sh_rise - last_main_rise;
  endtask

  task automatic check_setting(input int field, input int lag, input string req);
    longint per, hi, lg;
    int d;
    d = exp_period(field);
    meas(per, hi);
    chk(per == longint'(d * OT), req, per / OT, d);
    chk(hi == longint'(exp_high(d) * OT), req, hi / OT, exp_high(d));
    meas_lag(exp_lag(lag, d), lg);
    chk(lg == longint'(exp_lag(lag, d) * OT), req, lg / OT, exp_lag(lag, d));
  endtask

  initial begin
    int v;
    longint per, hi, lg;
    int rnd;
    rnd = $urandom(32'd2024);
    #101;
    bus_rst_n = 1'b1;
    osc_rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, v); chk(v == 16, "R1", v, 16);
    rd(1'b1, v); chk(v == 0, "R1", v, 0);
    #(OT * 40);
    check_setting(16, 0, "R1");

    // R9 raw readback of an out-of-range lag
    wr(1'b1, 200);
    rd(1'b1, v); chk(v == 200, "R9", v, 200);
    rd(1'b0, v); chk(v == 16, "R9", v, 16);
    wr(1'b1, 0);
    settle();

    // R2 directed ratios
    wr(1'b0, 2);   settle(); check_setting(2, 0, "R2");
    wr(1'b0, 3);   settle(); check_setting(3, 0, "R2");
    wr(1'b0, 255); settle(); check_setting(255, 0, "R2");

    // R3 zero field
    wr(1'b0, 0); settle(); check_setting(0, 0, "R3");

    // R4 pass-through, with a lag that must clamp to zero
    wr(1'b0, 1); wr(1'b1, 5); settle();
    meas(per, hi);
    chk(per == OT, "R4", per, OT);
    chk(hi == OT / 2, "R4", hi, OT / 2);
    @(posedge clk_main); #2;
    chk(last_sh_rise == last_main_rise, "R4", last_sh_rise, last_main_rise);

    // R7 lag and R8 clamp
    wr(1'b0, 10); wr(1'b1, 3); settle(); check_setting(10, 3, "R7");
    wr(1'b1, 0); settle(); check_setting(10, 0, "R7");
    wr(1'b0, 8); wr(1'b1, 20); settle(); check_setting(8, 20, "R8");
    wr(1'b1, 0); settle();

    // R10 back-to-back writes: last wins
    @(negedge bus_clk);
    reg_wr_en = 1'b1; reg_addr = 1'b0; reg_wdata = 8'd5;
    @(negedge bus_clk);
    reg_wdata = 8'd9;
    @(negedge bus_clk);
    reg_wr_en = 1'b0;
    settle();
    check_setting(9, 0, "R10");
    rd(1'b0, v); chk(v == 9, "R10", v, 9);

    // R6 changes landing mid-period
    for (int k = 0; k < 4; k++) begin
      int nd;
      int od;
      od = (k == 0) ? 9 : ((k % 2 == 1) ? 4 : 13);
      nd = (k % 2 == 0) ? 4 : 13;
      @(posedge clk_main);
      have_rise = 0; win_a = od; win_b = nd; per_en = 1;
      #(($urandom % 50) + 1);
      wr(1'b0, nd);
      settle();
      per_en = 0;
      chk(odd_periods == 0, "R6", odd_periods, 0);
    end

    // Constrained random ratios and lags
    for (int i = 0; i < 10; i++) begin
      int d;
      int lg_f;
      d    = 2 + int'($urandom % 60);
      lg_f = int'($urandom % (d + 3));
      #(($urandom % 40) + 1);
      wr(1'b0, d);
      wr(1'b1, lg_f);
      settle();
      check_setting(d, lg_f, (lg_f >= d) ? "R8" : "R7");
    end

    // R5 glitch-free across every change above
    chk(glitches == 0, "R5", glitches, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule